// File: doc/BRIEF.md
# Zero-Crossing Gated Wiper Updater

This block sits between the register-write path of a dual-channel audio attenuator and the tap switches of its two resistor ladders. When a write to a channel's wiper is acknowledged, the new 6-bit tap value arrives on a load interface. It does not reach the ladder at once. It is held as a pending value and moved onto the active wiper output only when that channel's signal crosses zero. A digital comparator bit reports that moment, when the high and low terminals sit at equal potential. This avoids audible clicks.

If no crossing arrives within a window of timer ticks, the pending value is forced through when the window ends. The window is 50 ticks by default, with one tick per millisecond. When the zero-crossing feature is switched off, an accepted load moves the wiper on the next clock edge. The two channels wait, time out and update on their own. A combined wait-complete flag tells the persistent-storage logic that no update is outstanding and a commit may begin.

The load interface is a valid/ready stream with `ld_ready` held high: a load is taken on every clock edge where `ld_valid` is high, and there is never back-pressure. The comparator bits, the enable, the tick and the outputs are plain level signals.

Top module: `zc_wiper_updater`

## Requirements
- R1: After reset both wiper outputs equal RESET_WIPER (default 63, the mute tap), `zc_done` is 1 and `ld_ready` is 1.
- R2: With `zc_enable` = 0, a load to channel c (`ld_chan` = c) appears on channel c's wiper field, `wiper_out[6c+5:6c]`, one clock edge after it is accepted, and `zc_done` stays 1.
- R3: With `zc_enable` = 1, an accepted load leaves that channel's wiper unchanged and drives `zc_done` to 0 from the next edge.
- R4: While a channel is pending, `zc_hit[c]` = 1 on a clock edge with no load to that channel moves the pending value onto the wiper at that edge. A `zc_hit` on the same edge as a load to that channel has no effect.
- R5: A pending channel that sees no crossing takes its pending value on the edge of the TIMEOUT_TICKS-th `ms_tick` after the load (default 50), and not before.
- R6: A crossing on one channel does not move the other channel's wiper.
- R7: A new load to a channel that is already pending replaces the pending value and restarts its tick count from zero.
- R8: `zc_done` is 1 exactly when no channel is pending. It stays 0 while any channel still waits.
- R9: Clearing `zc_enable` while a channel is pending applies that channel's pending value on the next edge.
- R10: Loads on consecutive cycles are all accepted, with each taking effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe; the write byte was acknowledged |
| ld_ready | output | 1 | Always 1; a load is never stalled |
| ld_chan | input | 1 | Target channel of the load |
| ld_value | input | 6 | New tap value |
| zc_hit | input | 2 | Per-channel comparator: terminals at equal potential |
| zc_enable | input | 1 | 1 = wait for a zero crossing; 0 = immediate update |
| ms_tick | input | 1 | One-cycle timer tick for the timeout window |
| wiper_out | output | 12 | Active taps; channel c occupies bits 6c+5..6c |
| zc_done | output | 1 | 1 when no update is pending; gates the storage commit |

## Verification
The properties assume that `ld_chan` always names an existing channel and that `zc_enable`, `zc_hit` and `ms_tick` are synchronous to `clk`. They also take `ms_tick` as a single-cycle pulse. The stimulus changes every input only at the falling clock edge and keeps the tick a one-cycle pulse. It drives only channel indices 0 and 1. The comparator bits are raised for a single cycle, as a synchronized comparator would deliver them.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
  localparam int ZCW_NCH      = 2;
  localparam int ZCW_VW       = 6;
  localparam int ZCW_TIMEOUT  = 50;
  localparam int ZCW_RESET_WP = 63;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_WAIT = 1'b1
  } ch_state_e;
endpackage

// File: rtl/zcw_tick_timer.sv
module zcw_tick_timer #(
  parameter int TIMEOUT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CNTW = $clog2(TIMEOUT + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(TIMEOUT - 1);

  logic [CNTW-1:0] cnt_q;

  assign expired = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (run && tick)  cnt_q <= expired ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/zcw_channel.sv
module zcw_channel
  import zcw_pkg::*;
#(
  parameter int VW       = 6,
  parameter int TIMEOUT  = 50,
  parameter int RESET_WP = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [VW-1:0] load_val,
  input  logic          zc_en,
  input  logic          zc_hit,
  input  logic          tick,
  output logic [VW-1:0] wiper,
  output logic          pending
);
  ch_state_e     state_q;
  logic [VW-1:0] pend_q;
  logic          timed_out;
  logic          apply_now;

  zcw_tick_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .run     (state_q == CH_WAIT),
    .tick    (tick),
    .expired (timed_out)
  );

  // a load on the same edge outranks every release condition
  assign apply_now = !load && (state_q == CH_WAIT) && (!zc_en || zc_hit || timed_out);
  assign pending   = (state_q == CH_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      pend_q  <= '0;
      wiper   <= VW'(RESET_WP);
    end else if (load) begin
      if (zc_en) begin
        pend_q  <= load_val;
        state_q <= CH_WAIT;
      end else begin
        wiper   <= load_val;
        state_q <= CH_IDLE;
      end
    end else if (apply_now) begin
      wiper   <= pend_q;
      state_q <= CH_IDLE;
    end
  end
endmodule

// File: rtl/zc_wiper_updater.sv
module zc_wiper_updater
  import zcw_pkg::*;
#(
  parameter int NCH      = ZCW_NCH,
  parameter int VW       = ZCW_VW,
  parameter int TIMEOUT  = ZCW_TIMEOUT,
  parameter int RESET_WP = ZCW_RESET_WP,
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CW-1:0]     ld_chan,
  input  logic [VW-1:0]     ld_value,
  input  logic [NCH-1:0]    zc_hit,
  input  logic              zc_enable,
  input  logic              ms_tick,
  output logic [NCH*VW-1:0] wiper_out,
  output logic              zc_done
);
  logic [NCH-1:0] pend_vec;

  assign ld_ready = 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_load;
    assign ch_load = ld_valid && (ld_chan == CW'(g));

    zcw_channel #(
      .VW       (VW),
      .TIMEOUT  (TIMEOUT),
      .RESET_WP (RESET_WP)
    ) i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ch_load),
      .load_val (ld_value),
      .zc_en    (zc_enable),
      .zc_hit   (zc_hit[g]),
      .tick     (ms_tick),
      .wiper    (wiper_out[g*VW +: VW]),
      .pending  (pend_vec[g])
    );
  end

  assign zc_done = ~|pend_vec;
endmodule

// File: rtl/zcw_checker.sv
module zcw_checker #(
  parameter int NCH = 2,
  parameter int VW  = 6,
  parameter int CW  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [CW-1:0]     ld_chan,
  input logic [VW-1:0]     ld_value,
  input logic [NCH-1:0]    zc_hit,
  input logic              zc_enable,
  input logic              ms_tick,
  input logic [NCH*VW-1:0] wiper_out,
  input logic              zc_done
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_BYPASS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid && !zc_enable && (ld_chan == CW'(g)) |=> wiper_out[g*VW +: VW] == $past(ld_value)); // R2
    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      zc_enable && !ld_valid && !zc_hit[g] && !ms_tick |=> $stable(wiper_out[g*VW +: VW])); // R3
  end

  AST_LOAD_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    zc_enable && ld_valid |=> !zc_done); // R3
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    zc_done && !(ld_valid && zc_enable) |=> zc_done); // R8
  AST_DISABLE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_enable && !ld_valid |=> zc_done); // R9
endmodule

bind zc_wiper_updater zcw_checker #(.NCH(NCH), .VW(VW), .CW(CW)) i_zcw_checker (.*);

// File: tb/test_zc_wiper_updater.sv
module test_zc_wiper_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_chan = 1'b0;
  logic [5:0]  ld_value = '0;
  logic [1:0]  zc_hit = '0;
  logic        zc_enable = 1'b0;
  logic        ms_tick = 1'b0;
  logic [11:0] wiper_out;
  logic        zc_done;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int          at;
    logic [11:0] wip;
    logic        done;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  zc_wiper_updater i_zc_wiper_updater (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (e.at != cyc || wiper_out !== e.wip || zc_done !== e.done) begin
        bad++;
        $display("FAIL %s: got wip=%h done=%b, expected wip=%h done=%b", e.tag, wiper_out, zc_done, e.wip, e.done);
      end
    end
  end

  // driver: applies one cycle of stimulus, queues the result due after the next edge
  task automatic go(input logic lv, input logic lc, input logic [5:0] val,
                    input logic [1:0] hit, input logic en, input logic tk,
                    input logic [5:0] w1, input logic [5:0] w0, input logic dn,
                    input string tag);
    exp_t e;
    ld_valid  = lv;
    ld_chan   = lc;
    ld_value  = val;
    zc_hit    = hit;
    zc_enable = en;
    ms_tick   = tk;
    e.at = cyc + 1; e.wip = {w1, w0}; e.done = dn; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (wiper_out !== {6'd63, 6'd63} || zc_done !== 1'b1 || ld_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1: got wip=%h done=%b rdy=%b, expected wip=fff done=1 rdy=1", wiper_out, zc_done, ld_ready);
    end

    // R2 immediate update when disabled
    go(1, 0, 6'd5,  2'b00, 0, 0, 63, 5, 1, "R2 ch0 immediate");
    go(1, 1, 6'd20, 2'b00, 0, 0, 20, 5, 1, "R2 ch1 immediate");

    // R3 / R6 / R4 gated update
    go(1, 0, 6'd40, 2'b00, 1, 0, 20, 5, 0, "R3 load pends");
    go(0, 0, 6'd0,  2'b00, 1, 0, 20, 5, 0, "R3 holds");
    go(0, 0, 6'd0,  2'b10, 1, 0, 20, 5, 0, "R6 other channel crossing");
    go(0, 0, 6'd0,  2'b01, 1, 0, 20, 40, 1, "R4 crossing applies, R8 done");

    // R5 timeout
    go(1, 1, 6'd33, 2'b00, 1, 0, 20, 40, 0, "R5 load ch1");
    for (int k = 1; k < 50; k++) go(0, 0, 6'd0, 2'b00, 1, 1, 20, 40, 0, "R5 before timeout");
    go(0, 0, 6'd0, 2'b00, 1, 1, 33, 40, 1, "R5 timeout applies");

    // R7 rewrite restarts window
    go(1, 0, 6'd10, 2'b00, 1, 0, 33, 40, 0, "R7 first load");
    for (int k = 0; k < 30; k++) go(0, 0, 6'd0, 2'b00, 1, 1, 33, 40, 0, "R7 partial window");
    go(1, 0, 6'd11, 2'b00, 1, 0, 33, 40, 0, "R7 rewrite");
    for (int k = 1; k < 50; k++) go(0, 0, 6'd0, 2'b00, 1, 1, 33, 40, 0, "R7 restarted window");
    go(0, 0, 6'd0, 2'b00, 1, 1, 33, 11, 1, "R7 replaced value applied");

    // R8 both channels pending
    go(1, 0, 6'd1, 2'b00, 1, 0, 33, 11, 0, "R8 ch0 pends");
    go(1, 1, 6'd2, 2'b00, 1, 0, 33, 11, 0, "R8 ch1 pends");
    go(0, 0, 6'd0, 2'b01, 1, 0, 33, 1, 0, "R8 one still pending");
    go(0, 0, 6'd0, 2'b10, 1, 0, 2, 1, 1, "R8 all released");

    // R9 disable flushes
    go(1, 1, 6'd7, 2'b00, 1, 0, 2, 1, 0, "R9 pends");
    go(0, 0, 6'd0, 2'b00, 0, 0, 7, 1, 1, "R9 disable applies");

    // R10 back-to-back loads
    go(1, 0, 6'd3, 2'b00, 0, 0, 7, 3, 1, "R10 first");
    go(1, 1, 6'd4, 2'b00, 0, 0, 4, 3, 1, "R10 second");
    go(1, 0, 6'd0, 2'b00, 0, 0, 4, 0, 1, "R10 third");

    // R4 crossing on the load edge is ignored
    go(1, 0, 6'd9, 2'b01, 1, 0, 4, 0, 0, "R4 same-edge crossing ignored");
    go(0, 0, 6'd0, 2'b01, 1, 0, 4, 9, 1, "R4 later crossing applies");
    go(0, 0, 6'd0, 2'b00, 1, 0, 4, 9, 1, "R8 idle done");

    @(negedge clk);
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: got %0d left, expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule